// File: doc/BRIEF.md
# Early-Exit Booth Multiplier

This block multiplies two 32-bit operands over several clock cycles and can add a third operand to the product. It returns the low 32 bits of `opRm * opRs`, or of `opRm * opRs + opRn` when accumulation is requested. The multiplier operand `opRs` is consumed two bits per cycle by radix-4 Booth recoding. Because the recoding carries the high bit of each pair into the next digit, every remaining digit is zero once the upper bits of `opRs` above the consumed span are zero. The block then stops at that point, so small multipliers finish in fewer cycles.

A one-cycle `start` pulse presents the operands and the option bits. All of them are captured on that cycle. After a number of cycles that depends only on the size of `opRs`, `done` pulses for one cycle and `result` carries the answer. `result` holds that value until the next operation completes. When the flag option was set, the negative and zero flags are updated from the 32-bit result. Otherwise they keep their previous values.

Top module: `early_exit_mul`

## Requirements
- R1: Without accumulation, `result` equals the low 32 bits of the unsigned product `opRm * opRs`.
- R2: With `accEn` high on the start cycle, `result` equals the low 32 bits of `opRm * opRs + opRn`.
- R3: When `start` is accepted in a cycle, `done` is high in the cycle that follows the k-th rising edge counted from the edge that samples `start`. k is 1 for `opRs` in 0..1, 2 for 2..7, and 3 for 8..0x1F.
- R4: k is the smallest value with `opRs` < 2^(2k-1), capped at 16. So 0x20..0x7F gives 4, 0x10000000..0x1FFFFFFF gives 15, and 0x20000000..0xFFFFFFFF gives 16.
- R5: An `opRs` with bit 31 set is treated as unsigned, and the low 32 bits of the result are still exact.
- R6: `done` is high for exactly one cycle per accepted operation, and `result` stays unchanged until the next completion.
- R7: When `setFlags` is high on the start cycle, `flagN` becomes bit 31 of the result and `flagZ` becomes 1 exactly when the result is zero. Both appear in the same cycle as `done`.
- R8: When `setFlags` is low on the start cycle, `flagN` and `flagZ` keep their previous values.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. It changes neither the running result nor its completion cycle, and it produces no later `done`.
- R10: Operands and option bits are sampled only on the accepted start cycle. Later changes on those ports do not affect the result.
- R11: After reset, `done`, `result`, `flagN` and `flagZ` are all zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation (accepted only when idle) |
| accEn | input | 1 | Add `opRn` to the product |
| setFlags | input | 1 | Update the N and Z flags on completion |
| opRm | input | 32 | Multiplicand |
| opRs | input | 32 | Multiplier; its magnitude sets the latency |
| opRn | input | 32 | Accumulate addend |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Low 32 bits of the product or product plus addend |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |

## Verification
The assertions check several things on every cycle. The step counter must count down by one while busy and stay below the ceiling. The result and flags must hold between completions or when flags are disabled. Updated flags must agree with the result written alongside them. Only the bench scenarios can show that the arithmetic is right, including accumulation and multipliers with bit 31 set. The same applies to the exact completion cycle at each range boundary of `opRs`. The scenarios also show that a start pulse during a busy period, or operand changes after acceptance, leave both the answer and its timing untouched.

// File: rtl/early_exit_mul_pkg.sv
package early_exit_mul_pkg;
  // strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic load;  // start accepted: take operands from the ports and do digit 0
    logic step;  // perform one more Booth digit from the held state
    logic last;  // the digit taken this cycle is the final one
  } mulStrobe_t;
endpackage

// File: rtl/mul_booth_pp.sv
module mul_booth_pp #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       triple,   // {b(2i+1), b(2i), b(2i-1)}
  input  logic [WIDTH-1:0] mcand,
  output logic [WIDTH-1:0] partial
);
  always_comb begin
    unique case (triple)
      3'b001, 3'b010: partial = mcand;
      3'b011:         partial = mcand << 1;
      3'b100:         partial = -(mcand << 1);
      3'b101, 3'b110: partial = -mcand;
      default:        partial = '0;
    endcase
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import early_exit_mul_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int MAX_STEPS = WIDTH / 2,
  parameter int CNT_W     = $clog2(MAX_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] opRs,
  output mulStrobe_t       strb,
  output logic             done
);
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] kSteps;
  logic             busy;
  logic             accept;

  assign busy   = (remain != '0);
  assign accept = start && !busy;

  // smallest k with opRs < 2^(2k-1), capped at MAX_STEPS
  always_comb begin
    kSteps = CNT_W'(MAX_STEPS);
    for (int i = MAX_STEPS - 1; i >= 1; i--) begin
      if ({1'b0, opRs} < ({{WIDTH{1'b0}}, 1'b1} << (2 * i - 1)))
        kSteps = CNT_W'(i);
    end
  end

  always_comb begin
    strb.load = accept;
    strb.step = busy;
    strb.last = (accept && kSteps == CNT_W'(1)) || (busy && remain == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
      done   <= 1'b0;
    end else begin
      if (accept)    remain <= kSteps - CNT_W'(1);
      else if (busy) remain <= remain - CNT_W'(1);
      done <= strb.last;
    end
  end

  // R9: while busy the count only moves down by one; a new start cannot reload it
  p_countdown_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (remain == $past(remain) - CNT_W'(1)));

  // R4: the step count never exceeds the ceiling
  p_step_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    remain < CNT_W'(MAX_STEPS));
endmodule

// File: rtl/mul_dp.sv
module mul_dp
  import early_exit_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobe_t       strb,
  input  logic             accEn,
  input  logic             setFlags,
  input  logic [WIDTH-1:0] opRm,
  input  logic [WIDTH-1:0] opRs,
  input  logic [WIDTH-1:0] opRn,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ
);
  logic [WIDTH-1:0] acc, mcand, mplier;
  logic             prevBit, flagsEnQ;
  logic [WIDTH-1:0] srcMcand, srcMplier, base, partial, accNext;
  logic             srcPrev, flagEnNow;

  always_comb begin
    srcMcand  = strb.load ? opRm : mcand;
    srcMplier = strb.load ? opRs : mplier;
    srcPrev   = strb.load ? 1'b0 : prevBit;
    base      = strb.load ? (accEn ? opRn : '0) : acc;
    flagEnNow = strb.load ? setFlags : flagsEnQ;
    accNext   = base + partial;
  end

  mul_booth_pp #(.WIDTH(WIDTH)) uBooth (
    .triple  ({srcMplier[1:0], srcPrev}),
    .mcand   (srcMcand),
    .partial (partial)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      mcand    <= '0;
      mplier   <= '0;
      prevBit  <= 1'b0;
      flagsEnQ <= 1'b0;
      result   <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
    end else begin
      if (strb.load || strb.step) begin
        acc     <= accNext;
        mcand   <= srcMcand << 2;
        mplier  <= srcMplier >> 2;
        prevBit <= srcMplier[1];
      end
      if (strb.load) flagsEnQ <= setFlags;
      if (strb.last) begin
        result <= accNext;
        if (flagEnNow) begin
          flagN <= accNext[WIDTH-1];
          flagZ <= (accNext == '0);
        end
      end
    end
  end

  // R6: result moves only on a completion
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.last |=> $stable(result));

  // R8: flags move only on a completion that asked for them
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.last && flagEnNow) |=> ($stable(flagN) && $stable(flagZ)));

  // R7: updated flags agree with the result written in the same cycle
  p_flags_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && flagEnNow) |=> ((flagZ == (result == '0)) && (flagN == result[WIDTH-1])));
endmodule

// File: rtl/early_exit_mul.sv
module early_exit_mul
  import early_exit_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             accEn,
  input  logic             setFlags,
  input  logic [WIDTH-1:0] opRm,
  input  logic [WIDTH-1:0] opRs,
  input  logic [WIDTH-1:0] opRn,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ
);
  mulStrobe_t strb;

  mul_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opRs  (opRs),
    .strb  (strb),
    .done  (done)
  );

  mul_dp #(.WIDTH(WIDTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .accEn    (accEn),
    .setFlags (setFlags),
    .opRm     (opRm),
    .opRs     (opRs),
    .opRn     (opRn),
    .result   (result),
    .flagN    (flagN),
    .flagZ    (flagZ)
  );

  // R3: a completion is always preceded by an accepted start or a busy cycle
  p_done_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(strb.load) || $past(strb.step)));
endmodule

// File: tb/tb_early_exit_mul.sv
`timescale 1ns/1ps
module tb_early_exit_mul;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, accEn = 1'b0, setFlags = 1'b0;
  logic [31:0] opRm = '0, opRs = '0, opRn = '0;
  logic        done, flagN, flagZ;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  logic expN = 1'b0, expZ = 1'b0;
  longint cycleCount = 0;

  always #2.5 clk = ~clk;

  early_exit_mul dut (
    .clk(clk), .rstN(rstN), .start(start), .accEn(accEn), .setFlags(setFlags),
    .opRm(opRm), .opRs(opRs), .opRn(opRn),
    .done(done), .result(result), .flagN(flagN), .flagZ(flagZ)
  );

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 100000)", cycleCount);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act 0x%08h exp 0x%08h", req, act, exp);
    end
  endtask

  function automatic int expSteps(input logic [31:0] rs);
    int k = 1;
    while (k < 16 && {32'd0, rs} >= (64'd1 << (2 * k - 1))) k++;
    return k;
  endfunction

  // run one operation; optional scrambling of ports after acceptance (R10)
  // and a stray start pulse while busy (R9)
  task automatic runOp(input string req, input logic [31:0] rm, input logic [31:0] rs,
                       input logic [31:0] rn, input logic acc, input logic sf,
                       input bit scramble, input bit poke);
    int n = 0;
    logic [31:0] expRes;
    expRes = rm * rs + (acc ? rn : 32'd0);
    @(negedge clk);
    opRm = rm; opRs = rs; opRn = rn; accEn = acc; setFlags = sf; start = 1'b1;
    @(posedge clk);
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        start = 1'b0;
        if (scramble) begin
          opRm = ~rm; opRs = 32'h0000_0001; opRn = ~rn; accEn = ~acc; setFlags = ~sf;
        end
      end
      if (poke && n == 3) begin
        opRm = 32'h1111_1111; opRs = 32'h3; opRn = 32'h5; accEn = 1'b1; start = 1'b1;
      end
      if (poke && n == 4) start = 1'b0;
      if (done || n > 40) break;
    end
    chk({req, " latency"}, n, expSteps(rs));
    chk({req, " result"}, result, expRes);
    if (sf) begin
      expN = expRes[31];
      expZ = (expRes == 32'd0);
    end
    chk({req, " flagN (R7/R8)"}, {31'd0, flagN}, {31'd0, expN});
    chk({req, " flagZ (R7/R8)"}, {31'd0, flagZ}, {31'd0, expZ});
    if (poke) begin
      int stray = 0;
      for (int c = 0; c < 24; c++) begin
        @(negedge clk);
        if (done) stray++;
      end
      chk("R9 no done from ignored start", stray, 0);
      chk("R9 result kept", result, expRes);
    end
  endtask

  task automatic tReset();
    chk("R11 done after reset", {31'd0, done}, 32'd0);
    chk("R11 result after reset", result, 32'd0);
    chk("R11 flags after reset", {30'd0, flagN, flagZ}, 32'd0);
  endtask

  task automatic tLatencyTable();
    logic [31:0] rsList [14] = '{32'd0, 32'd1, 32'd2, 32'd7, 32'd8, 32'h1F, 32'h20,
                                 32'h7F, 32'h80, 32'h0000_FFFF, 32'h1000_0000,
                                 32'h1FFF_FFFF, 32'h2000_0000, 32'h7FFF_FFFF};
    foreach (rsList[i])
      runOp("R1/R3/R4 range", 32'hA5C3_1F27, rsList[i], 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tHighBit();
    runOp("R5 rs=FFFFFFFF", 32'h1234_5679, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    runOp("R5 rs=80000001", 32'hDEAD_BEEF, 32'h8000_0001, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    runOp("R5 rs=C0000003 rm neg", 32'hFFFF_FFFD, 32'hC000_0003, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tAccumulate();
    runOp("R2 acc", 32'h1234_5678, 32'h0000_9ABC, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 1'b0);
    runOp("R2 acc rs=0", 32'h1234_5678, 32'd0, 32'h0BAD_F00D, 1'b1, 1'b0, 1'b0, 1'b0);
    runOp("R2 acc wrap", 32'hFFFF_FFFF, 32'h0000_0005, 32'd5, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tFlags();
    runOp("R7 zero", 32'h8000_0000, 32'd2, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    runOp("R8 hold", 32'hFFFF_FFFF, 32'd3, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    runOp("R7 negative", 32'hFFFF_FFFF, 32'd3, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    runOp("R7 positive", 32'd6, 32'd7, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tHold();
    logic [31:0] keep;
    runOp("R6 base", 32'h0F0F_0F0F, 32'h0000_0333, 32'd9, 1'b1, 1'b0, 1'b0, 1'b0);
    keep = result;
    opRm = 32'hCAFE_0001; opRs = 32'h1234; opRn = 32'h77;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R6 done low after pulse", {31'd0, done}, 32'd0);
      chk("R6 result held", result, keep);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLatencyTable();
    tHighBit();
    tAccumulate();
    tFlags();
    runOp("R10 capture", 32'h0765_4321, 32'h00AB_CDEF, 32'h1357_9BDF, 1'b1, 1'b1, 1'b1, 1'b0);
    runOp("R9 busy start", 32'h0246_8ACE, 32'hF000_0001, 32'h0000_0100, 1'b1, 1'b0, 1'b0, 1'b1);
    tHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule